// File: doc/BRIEF.md
# PCIe Legacy and MSI Interrupt Aggregator

This block gathers the interrupt traffic that arrives from a PCIe link in a root-complex role. It handles two kinds of traffic. The first is legacy line-interrupt messages, which carry a line index from 0 to 3 and an assert or deassert flag. The second is inbound memory writes. A write whose address equals a programmed 64-bit target is decoded as a message-signalled interrupt. Every event sets a bit in a write-1-to-clear status register, and each status register has its own mask register.

The registers form a two-level tree. The line-event status register and an auxiliary status register feed a single core bit in a top summary register. The auxiliary register holds a power-state-change event and a flush event. A mask on the top bit gates the one registered, active-high interrupt output.

An MSI write sets a bit in a 32-entry vector status register. The vector number is the low five bits of the write data. The low eight bits of the data are kept in a payload register. When the addressed vector is enabled, the write also raises an MSI-pending bit in the line-event register. Software clears the individual vector bits first and the pending bit after that.

Top module: `irqagg_top`

## Requirements
- R1: After reset every status register, the payload and both target-address halves read 0, and `irq_o` is 0. The masks reset fully masked: the line-event mask reads 0x07FFFFFF, the auxiliary mask 0x00000030, the vector mask 0xFFFFFFFF and the top mask 0x00010000. Register index on `reg_addr`: 0 line-event status, 1 its mask, 2 auxiliary status, 3 its mask, 4 target low, 5 target high, 6 vector status, 7 vector mask, 8 payload, 9 top status, 10 top mask.
- R2: A line message with index n sets line-event status bit 16+n when it asserts and bit 20+n when it deasserts. The bit is set at the clock edge that samples the message, and it is set whatever the mask holds.
- R3: A register write to a status register clears exactly the bits written as 1 and leaves the bits written as 0 unchanged. Mask registers keep only their valid field (line-event mask bits 26:0, auxiliary mask bits 5:4, top mask bit 16), and every other bit reads as 0.
- R4: If a hardware event and a write-1 clear reach the same status bit in the same cycle, the bit ends up set.
- R5: An inbound write whose 64-bit address equals {target high, target low} sets vector-status bit data[4:0] and loads data[7:0] into the payload register. A write to any other address changes neither register.
- R6: A matching inbound write sets line-event bit 24 only when the vector-mask bit of the addressed vector is 0.
- R7: The power-state-change event sets auxiliary status bit 4, and the flush event sets bit 5.
- R8: Top status bit 16 is set one cycle after (line-event status AND NOT its mask) or (auxiliary status AND NOT its mask) becomes nonzero. Masked sources never set it.
- R9: `irq_o` is a register. It goes high one cycle after top bit 16 is set while top-mask bit 16 is 0, and it stays low while that mask bit is 1.
- R10: Top bit 16 is write-1-to-clear. A clear that is written while an unmasked source is still pending leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register index |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data (combinational from reg_addr) |
| intx_valid | input | 1 | Line-interrupt message strobe |
| intx_line | input | 2 | Line index, 0..3 |
| intx_deassert | input | 1 | 1 = deassert message, 0 = assert message |
| inb_valid | input | 1 | Inbound memory-write strobe |
| inb_addr | input | 2*REG_W | Inbound write address |
| inb_data | input | MSI_DATA_W | Inbound write data |
| evt_power | input | 1 | Power-state-change event pulse |
| evt_flush | input | 1 | Flush event pulse |
| irq_o | output | 1 | Summary interrupt, active high |

## Verification
The line path is driven with an assert on one line and a deassert on another. This shows that the two messages land in separate bit groups and that each write-1 clear removes only the bit it names. Three inbound writes are used: one to the matching address with an enabled vector, one to an address that differs only in the upper half, and one to the matching address with a masked vector. Together they separate address matching, payload capture and gating of the pending bit. Both auxiliary events are tried with their mask open and closed. A line event combined with a clear in the same cycle, and a top-level clear issued while a source is still pending, show which side wins when set and clear collide.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
   // bit positions inside the line-event status register
   localparam int unsigned ASSERT_BASE   = 16;
   localparam int unsigned DEASSERT_BASE = 20;
   localparam int unsigned MSI_PEND_BIT  = 24;
   // auxiliary register and top register positions
   localparam int unsigned PWR_BIT       = 4;
   localparam int unsigned FLUSH_BIT     = 5;
   localparam int unsigned TOP_BIT       = 16;

   localparam logic [31:0] L1_MASK_VALID = 32'h07FF_FFFF;
   localparam logic [31:0] L1_SOURCED    = 32'h01FF_0000;
   localparam logic [31:0] AUX_VALID     = 32'h0000_0030;
   localparam logic [31:0] TOP_VALID     = 32'h0001_0000;

   typedef enum logic [3:0] {
      RA_L1_STAT  = 4'd0,
      RA_L1_MASK  = 4'd1,
      RA_AUX_STAT = 4'd2,
      RA_AUX_MASK = 4'd3,
      RA_TGT_LO   = 4'd4,
      RA_TGT_HI   = 4'd5,
      RA_VEC_STAT = 4'd6,
      RA_VEC_MASK = 4'd7,
      RA_PAYLOAD  = 4'd8,
      RA_TOP_STAT = 4'd9,
      RA_TOP_MASK = 4'd10
   } reg_addr_e;
endpackage

// File: rtl/irqagg_w1c_bank.sv
// Status bank: hardware set has priority over a software write-1 clear.
module irqagg_w1c_bank #(
   parameter int unsigned W = 32,
   parameter logic [W-1:0] VALID = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] stat_o
);
   logic unused_in;
   assign unused_in = ^(set_i | clr_i);

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (VALID[i]) begin : g_flop
         logic b;
         always_ff @(posedge clk) begin
            if (!rst_n) b <= 1'b0;
            else        b <= set_i[i] | (b & ~clr_i[i]);
         end
         assign stat_o[i] = b;
      end else begin : g_zero
         assign stat_o[i] = 1'b0;
      end
   end
endmodule

// File: rtl/irqagg_rw_reg.sv
// Plain read/write register; bits outside VALID are held at zero.
module irqagg_rw_reg #(
   parameter int unsigned W = 32,
   parameter logic [W-1:0] RST = '0,
   parameter logic [W-1:0] VALID = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= RST & VALID;
      else if (we) q <= wdata & VALID;
   end
endmodule

// File: rtl/irqagg_msi_unit.sv
// Address match, vector status and payload capture for inbound MSI writes.
module irqagg_msi_unit #(
   parameter int unsigned ADDR_BITS = 64,
   parameter int unsigned VEC       = 32,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned PAY_W     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 inb_valid,
   input  logic [ADDR_BITS-1:0] inb_addr,
   input  logic [DATA_W-1:0]    inb_data,
   input  logic [ADDR_BITS-1:0] target,
   input  logic [VEC-1:0]       vec_mask,
   input  logic [VEC-1:0]       vec_clr,
   output logic [VEC-1:0]       vec_stat,
   output logic [PAY_W-1:0]     payload,
   output logic                 hit,
   output logic                 fire
);
   localparam int unsigned IDX_W = $clog2(VEC);

   logic [IDX_W-1:0] idx;
   logic [VEC-1:0]   vec_set;
   logic             unused_data;

   assign idx         = inb_data[IDX_W-1:0];
   assign hit         = inb_valid && (inb_addr == target);
   assign fire        = hit && !vec_mask[idx];
   assign vec_set     = hit ? (VEC'(1) << idx) : '0;
   assign unused_data = ^inb_data;

   irqagg_w1c_bank #(.W(VEC), .VALID('1)) u_vec (
      .clk(clk), .rst_n(rst_n), .set_i(vec_set), .clr_i(vec_clr), .stat_o(vec_stat)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)   payload <= '0;
      else if (hit) payload <= inb_data[PAY_W-1:0];
   end
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
   import irqagg_pkg::*;
#(
   parameter int unsigned REG_W      = 32,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned INTX_LINES = 4,
   parameter int unsigned MSI_VEC    = 32,
   parameter int unsigned MSI_DATA_W = 16,
   parameter int unsigned PAY_W      = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wen,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [REG_W-1:0]      reg_wdata,
   output logic [REG_W-1:0]      reg_rdata,
   input  logic                  intx_valid,
   input  logic [1:0]            intx_line,
   input  logic                  intx_deassert,
   input  logic                  inb_valid,
   input  logic [2*REG_W-1:0]    inb_addr,
   input  logic [MSI_DATA_W-1:0] inb_data,
   input  logic                  evt_power,
   input  logic                  evt_flush,
   output logic                  irq_o
);
   localparam int unsigned TGT_W = 2 * REG_W;

   // elaboration-time parameter checks
   if (REG_W != 32) begin : g_bad_regw
      $error("irqagg_top: REG_W must be 32");
   end
   if (ADDR_W < 4) begin : g_bad_addrw
      $error("irqagg_top: ADDR_W must be at least 4");
   end
   if (INTX_LINES < 1 || INTX_LINES > 4) begin : g_bad_lines
      $error("irqagg_top: INTX_LINES must be 1..4");
   end
   if (MSI_VEC < 2 || MSI_VEC > REG_W || (MSI_VEC & (MSI_VEC - 1)) != 0) begin : g_bad_vec
      $error("irqagg_top: MSI_VEC must be a power of two up to REG_W");
   end
   if (PAY_W > MSI_DATA_W || $clog2(MSI_VEC) > PAY_W) begin : g_bad_pay
      $error("irqagg_top: payload width out of range");
   end

   function automatic logic wr_to(input reg_addr_e a);
      return reg_wen && (reg_addr == ADDR_W'(a));
   endfunction

   logic [REG_W-1:0]   l1_stat_q, l1_mask_q, l1_set, l1_clr;
   logic [REG_W-1:0]   aux_stat_q, aux_mask_q, aux_set, aux_clr;
   logic [REG_W-1:0]   top_stat_q, top_mask_q, top_set, top_clr;
   logic [REG_W-1:0]   tgt_lo_q, tgt_hi_q;
   logic [MSI_VEC-1:0] vec_stat_q, vec_mask_q, vec_clr;
   logic [PAY_W-1:0]   payload_q;
   logic               msi_hit, msi_fire, core_pend, irq_q;

   // ---------------- line-event level ----------------
   always_comb begin
      l1_set = '0;
      for (int n = 0; n < INTX_LINES; n++) begin
         if (intx_valid && intx_line == 2'(n)) begin
            if (intx_deassert) l1_set[DEASSERT_BASE + n] = 1'b1;
            else               l1_set[ASSERT_BASE + n]   = 1'b1;
         end
      end
      l1_set[MSI_PEND_BIT] = msi_fire;
   end
   assign l1_clr = wr_to(RA_L1_STAT) ? reg_wdata : '0;

   irqagg_w1c_bank #(.W(REG_W), .VALID(L1_SOURCED)) u_l1_stat (
      .clk(clk), .rst_n(rst_n), .set_i(l1_set), .clr_i(l1_clr), .stat_o(l1_stat_q)
   );
   irqagg_rw_reg #(.W(REG_W), .RST('1), .VALID(L1_MASK_VALID)) u_l1_mask (
      .clk(clk), .rst_n(rst_n), .we(wr_to(RA_L1_MASK)), .wdata(reg_wdata), .q(l1_mask_q)
   );

   // ---------------- auxiliary level ----------------
   always_comb begin
      aux_set            = '0;
      aux_set[PWR_BIT]   = evt_power;
      aux_set[FLUSH_BIT] = evt_flush;
   end
   assign aux_clr = wr_to(RA_AUX_STAT) ? reg_wdata : '0;

   irqagg_w1c_bank #(.W(REG_W), .VALID(AUX_VALID)) u_aux_stat (
      .clk(clk), .rst_n(rst_n), .set_i(aux_set), .clr_i(aux_clr), .stat_o(aux_stat_q)
   );
   irqagg_rw_reg #(.W(REG_W), .RST('1), .VALID(AUX_VALID)) u_aux_mask (
      .clk(clk), .rst_n(rst_n), .we(wr_to(RA_AUX_MASK)), .wdata(reg_wdata), .q(aux_mask_q)
   );

   // ---------------- MSI path ----------------
   irqagg_rw_reg #(.W(REG_W), .RST('0), .VALID('1)) u_tgt_lo (
      .clk(clk), .rst_n(rst_n), .we(wr_to(RA_TGT_LO)), .wdata(reg_wdata), .q(tgt_lo_q)
   );
   irqagg_rw_reg #(.W(REG_W), .RST('0), .VALID('1)) u_tgt_hi (
      .clk(clk), .rst_n(rst_n), .we(wr_to(RA_TGT_HI)), .wdata(reg_wdata), .q(tgt_hi_q)
   );
   irqagg_rw_reg #(.W(MSI_VEC), .RST('1), .VALID('1)) u_vec_mask (
      .clk(clk), .rst_n(rst_n), .we(wr_to(RA_VEC_MASK)), .wdata(reg_wdata[MSI_VEC-1:0]),
      .q(vec_mask_q)
   );
   assign vec_clr = wr_to(RA_VEC_STAT) ? reg_wdata[MSI_VEC-1:0] : '0;

   irqagg_msi_unit #(.ADDR_BITS(TGT_W), .VEC(MSI_VEC), .DATA_W(MSI_DATA_W), .PAY_W(PAY_W)) u_msi (
      .clk(clk), .rst_n(rst_n), .inb_valid(inb_valid), .inb_addr(inb_addr),
      .inb_data(inb_data), .target({tgt_hi_q, tgt_lo_q}), .vec_mask(vec_mask_q),
      .vec_clr(vec_clr), .vec_stat(vec_stat_q), .payload(payload_q),
      .hit(msi_hit), .fire(msi_fire)
   );

   // ---------------- top summary ----------------
   assign core_pend = (|(l1_stat_q & ~l1_mask_q)) | (|(aux_stat_q & ~aux_mask_q));
   assign top_set   = REG_W'(core_pend) << TOP_BIT;
   assign top_clr   = wr_to(RA_TOP_STAT) ? reg_wdata : '0;

   irqagg_w1c_bank #(.W(REG_W), .VALID(TOP_VALID)) u_top_stat (
      .clk(clk), .rst_n(rst_n), .set_i(top_set), .clr_i(top_clr), .stat_o(top_stat_q)
   );
   irqagg_rw_reg #(.W(REG_W), .RST('1), .VALID(TOP_VALID)) u_top_mask (
      .clk(clk), .rst_n(rst_n), .we(wr_to(RA_TOP_MASK)), .wdata(reg_wdata), .q(top_mask_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= top_stat_q[TOP_BIT] & ~top_mask_q[TOP_BIT];
   end
   assign irq_o = irq_q;

   // ---------------- read mux ----------------
   always_comb begin
      case (reg_addr)
         ADDR_W'(RA_L1_STAT):  reg_rdata = l1_stat_q;
         ADDR_W'(RA_L1_MASK):  reg_rdata = l1_mask_q;
         ADDR_W'(RA_AUX_STAT): reg_rdata = aux_stat_q;
         ADDR_W'(RA_AUX_MASK): reg_rdata = aux_mask_q;
         ADDR_W'(RA_TGT_LO):   reg_rdata = tgt_lo_q;
         ADDR_W'(RA_TGT_HI):   reg_rdata = tgt_hi_q;
         ADDR_W'(RA_VEC_STAT): reg_rdata = REG_W'(vec_stat_q);
         ADDR_W'(RA_VEC_MASK): reg_rdata = REG_W'(vec_mask_q);
         ADDR_W'(RA_PAYLOAD):  reg_rdata = REG_W'(payload_q);
         ADDR_W'(RA_TOP_STAT): reg_rdata = top_stat_q;
         ADDR_W'(RA_TOP_MASK): reg_rdata = top_mask_q;
         default:              reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk
   import irqagg_pkg::*;
#(
   parameter int unsigned REG_W      = 32,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned INTX_LINES = 4,
   parameter int unsigned MSI_VEC    = 32,
   parameter int unsigned MSI_DATA_W = 16,
   parameter int unsigned PAY_W      = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  reg_wen,
   input logic [ADDR_W-1:0]     reg_addr,
   input logic                  wdata_a0,
   input logic                  intx_valid,
   input logic [1:0]            intx_line,
   input logic                  intx_deassert,
   input logic [MSI_DATA_W-1:0] inb_data,
   input logic                  msi_hit,
   input logic [REG_W-1:0]      l1_stat,
   input logic [REG_W-1:0]      l1_mask,
   input logic                  top_bit,
   input logic                  top_mask_bit,
   input logic [MSI_VEC-1:0]    vec_stat,
   input logic [PAY_W-1:0]      payload,
   input logic                  irq_o
);
   localparam int unsigned IDX_W = $clog2(MSI_VEC);

   logic unused_data;
   assign unused_data = ^inb_data;

   // R2: an assert message lands in bit 16+n at the next edge
   p_intx_assert_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (intx_valid && !intx_deassert && int'(intx_line) < INTX_LINES)
      |=> l1_stat[ASSERT_BASE + int'($past(intx_line))]);

   // R2: a deassert message lands in bit 20+n
   p_intx_deassert_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (intx_valid && intx_deassert && int'(intx_line) < INTX_LINES)
      |=> l1_stat[DEASSERT_BASE + int'($past(intx_line))]);

   // R3: line-A assert bit only falls after a write-1 to the status register
   p_clear_only_by_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(l1_stat[ASSERT_BASE])
      |-> $past(reg_wen && reg_addr == ADDR_W'(RA_L1_STAT) && wdata_a0));

   // R5: a matching write records its vector and payload
   p_msi_record_r5: assert property (@(posedge clk) disable iff (!rst_n)
      msi_hit |=> (vec_stat[$past(inb_data[IDX_W-1:0])]
                   && payload == $past(inb_data[PAY_W-1:0])));

   // R8: unmasked line-event activity reaches the top bit one cycle later
   p_top_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(l1_stat & ~l1_mask)) |=> top_bit);

   // R9: output follows the gated top bit with one register stage
   p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (top_bit && !top_mask_bit) |=> irq_o);

   p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!top_bit || top_mask_bit) |=> !irq_o);
endmodule

bind irqagg_top irqagg_chk #(
   .REG_W(REG_W), .ADDR_W(ADDR_W), .INTX_LINES(INTX_LINES),
   .MSI_VEC(MSI_VEC), .MSI_DATA_W(MSI_DATA_W), .PAY_W(PAY_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
   .wdata_a0(reg_wdata[irqagg_pkg::ASSERT_BASE]),
   .intx_valid(intx_valid), .intx_line(intx_line), .intx_deassert(intx_deassert),
   .inb_data(inb_data), .msi_hit(msi_hit), .l1_stat(l1_stat_q), .l1_mask(l1_mask_q),
   .top_bit(top_stat_q[irqagg_pkg::TOP_BIT]), .top_mask_bit(top_mask_q[irqagg_pkg::TOP_BIT]),
   .vec_stat(vec_stat_q), .payload(payload_q), .irq_o(irq_o)
);

// File: tb/irqagg_top_test.sv
module irqagg_top_test;
   import irqagg_pkg::*;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wen = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        intx_valid = 1'b0;
   logic [1:0]  intx_line = '0;
   logic        intx_deassert = 1'b0;
   logic        inb_valid = 1'b0;
   logic [63:0] inb_addr = '0;
   logic [15:0] inb_data = '0;
   logic        evt_power = 1'b0;
   logic        evt_flush = 1'b0;
   logic        irq_o;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   localparam logic [63:0] TGT = 64'h0000_0001_1000_0040;

   irqagg_top uut (
      .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .intx_valid(intx_valid),
      .intx_line(intx_line), .intx_deassert(intx_deassert), .inb_valid(inb_valid),
      .inb_addr(inb_addr), .inb_data(inb_data), .evt_power(evt_power),
      .evt_flush(evt_flush), .irq_o(irq_o)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 50000 && !done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got cycle %0d exp completion", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %08h exp %08h", req, got, exp);
      end
   endtask

   task automatic wr(input reg_addr_e a, input logic [31:0] d);
      @(negedge clk);
      reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wen = 1'b0;
   endtask

   task automatic rd_chk(input string req, input reg_addr_e a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      chk(req, reg_rdata, exp);
   endtask

   task automatic line_msg(input logic [1:0] ln, input logic deass);
      @(negedge clk);
      intx_valid = 1'b1; intx_line = ln; intx_deassert = deass;
      @(negedge clk);
      intx_valid = 1'b0;
   endtask

   task automatic inb_wr(input logic [63:0] a, input logic [15:0] d);
      @(negedge clk);
      inb_valid = 1'b1; inb_addr = a; inb_data = d;
      @(negedge clk);
      inb_valid = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // return every status to zero and let the output settle
   task automatic clean_all();
      wr(RA_L1_STAT, 32'hFFFF_FFFF);
      wr(RA_AUX_STAT, 32'hFFFF_FFFF);
      wr(RA_VEC_STAT, 32'hFFFF_FFFF);
      wr(RA_TOP_STAT, 32'hFFFF_FFFF);
      wait_cyc(2);
   endtask

   task automatic t_reset();
      rd_chk("R1 line status", RA_L1_STAT, 32'h0);
      rd_chk("R1 line mask", RA_L1_MASK, 32'h07FF_FFFF);
      rd_chk("R1 aux mask", RA_AUX_MASK, 32'h0000_0030);
      rd_chk("R1 vector mask", RA_VEC_MASK, 32'hFFFF_FFFF);
      rd_chk("R1 top mask", RA_TOP_MASK, 32'h0001_0000);
      rd_chk("R1 top status", RA_TOP_STAT, 32'h0);
      rd_chk("R1 target low", RA_TGT_LO, 32'h0);
      rd_chk("R1 payload", RA_PAYLOAD, 32'h0);
      chk("R1 irq", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_line_path();
      wr(RA_L1_MASK, 32'h0);
      wr(RA_TOP_MASK, 32'h0);
      line_msg(2'd2, 1'b0);
      rd_chk("R2 assert line 2", RA_L1_STAT, 32'h0004_0000);
      rd_chk("R8 top not yet", RA_TOP_STAT, 32'h0);
      @(negedge clk);
      rd_chk("R8 top set", RA_TOP_STAT, 32'h0001_0000);
      chk("R9 irq not yet", {31'b0, irq_o}, 32'h0);
      @(negedge clk);
      chk("R9 irq high", {31'b0, irq_o}, 32'h1);
      line_msg(2'd1, 1'b1);
      rd_chk("R2 deassert line 1", RA_L1_STAT, 32'h0024_0000);
      wr(RA_L1_STAT, 32'h0004_0000);
      rd_chk("R3 partial clear", RA_L1_STAT, 32'h0020_0000);
      wr(RA_TOP_STAT, 32'h0001_0000);
      rd_chk("R10 clear while pending", RA_TOP_STAT, 32'h0001_0000);
      wr(RA_L1_STAT, 32'hFFFF_FFFF);
      rd_chk("R3 full clear", RA_L1_STAT, 32'h0);
      wr(RA_TOP_STAT, 32'h0001_0000);
      rd_chk("R10 clear when idle", RA_TOP_STAT, 32'h0);
      @(negedge clk);
      chk("R9 irq low", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_masked();
      wr(RA_L1_MASK, 32'hFFFF_FFFF);
      rd_chk("R3 mask valid field", RA_L1_MASK, 32'h07FF_FFFF);
      line_msg(2'd0, 1'b0);
      rd_chk("R2 recorded while masked", RA_L1_STAT, 32'h0001_0000);
      wait_cyc(3);
      rd_chk("R8 masked no top", RA_TOP_STAT, 32'h0);
      chk("R9 masked no irq", {31'b0, irq_o}, 32'h0);
      clean_all();
      wr(RA_L1_MASK, 32'h0);
      // top mask closed: top bit sets but output stays low
      wr(RA_TOP_MASK, 32'h0001_0000);
      line_msg(2'd0, 1'b0);
      wait_cyc(3);
      rd_chk("R8 top set under top mask", RA_TOP_STAT, 32'h0001_0000);
      chk("R9 top mask holds irq low", {31'b0, irq_o}, 32'h0);
      clean_all();
      wr(RA_TOP_MASK, 32'h0);
   endtask

   task automatic t_set_wins();
      @(negedge clk);
      intx_valid = 1'b1; intx_line = 2'd3; intx_deassert = 1'b0;
      reg_wen = 1'b1; reg_addr = RA_L1_STAT; reg_wdata = 32'h0008_0000;
      @(negedge clk);
      intx_valid = 1'b0; reg_wen = 1'b0;
      rd_chk("R4 set beats clear", RA_L1_STAT, 32'h0008_0000);
      clean_all();
      rd_chk("R4 cleanup top", RA_TOP_STAT, 32'h0);
      chk("R4 cleanup irq", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_msi();
      wr(RA_TGT_LO, TGT[31:0]);
      wr(RA_TGT_HI, TGT[63:32]);
      wr(RA_VEC_MASK, ~(32'h1 << 5));
      inb_wr(TGT, 16'h00A5);
      rd_chk("R5 vector 5 set", RA_VEC_STAT, 32'h0000_0020);
      rd_chk("R5 payload", RA_PAYLOAD, 32'h0000_00A5);
      rd_chk("R6 pending on enabled vector", RA_L1_STAT, 32'h0100_0000);
      inb_wr(TGT ^ 64'h0000_0003_0000_0000, 16'h0033);
      rd_chk("R5 other address ignored", RA_VEC_STAT, 32'h0000_0020);
      rd_chk("R5 payload kept", RA_PAYLOAD, 32'h0000_00A5);
      wr(RA_VEC_STAT, 32'h0000_0020);
      wr(RA_L1_STAT, 32'h0100_0000);
      rd_chk("R3 vector cleared", RA_VEC_STAT, 32'h0);
      inb_wr(TGT, 16'h0007);
      rd_chk("R5 masked vector still recorded", RA_VEC_STAT, 32'h0000_0080);
      rd_chk("R5 payload updated", RA_PAYLOAD, 32'h0000_0007);
      rd_chk("R6 no pending on masked vector", RA_L1_STAT, 32'h0);
      clean_all();
   endtask

   task automatic t_aux();
      wr(RA_AUX_MASK, 32'h0);
      @(negedge clk); evt_power = 1'b1;
      @(negedge clk); evt_power = 1'b0;
      rd_chk("R7 power event", RA_AUX_STAT, 32'h0000_0010);
      @(negedge clk);
      rd_chk("R8 aux reaches top", RA_TOP_STAT, 32'h0001_0000);
      @(negedge clk); evt_flush = 1'b1;
      @(negedge clk); evt_flush = 1'b0;
      rd_chk("R7 flush event", RA_AUX_STAT, 32'h0000_0030);
      clean_all();
      wr(RA_AUX_MASK, 32'h0000_0030);
      @(negedge clk); evt_flush = 1'b1;
      @(negedge clk); evt_flush = 1'b0;
      rd_chk("R7 flush while masked", RA_AUX_STAT, 32'h0000_0020);
      wait_cyc(2);
      rd_chk("R8 masked aux no top", RA_TOP_STAT, 32'h0);
      chk("R9 masked aux no irq", {31'b0, irq_o}, 32'h0);
   endtask

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      t_reset();
      t_line_path();
      t_masked();
      t_set_wins();
      t_msi();
      t_aux();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule